// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen architectural registers of a processor core together with the saved status word. Several of these registers have private copies for each privileged operating mode. A mode-change request carries a 5-bit mode code. When the request is accepted, the block makes a different set of copies visible: the stack pointer (register 13), the link register (register 14) and the saved status word.

Fast-interrupt mode also keeps its own copies of registers 8 to 12. Registers 0 to 7 and register 15 are the same in every mode. User and system mode share one bank.

The block does not move data between copies when the mode changes. Every copy lives at a fixed place in storage, and the current mode only selects which copy the read and write ports reach. A mode change is therefore one register update, and its effect is the same as saving the old mode's values and loading the new mode's. A mode code outside the legal set raises an error flag for one cycle, and all state stays as it was.

Top module: `mode_bank_regfile`

## Requirements
- R1: After reset the current mode is supervisor (0x13), every register and the saved status word read zero in every mode, and `mode_err` is low.
- R2: Legal mode codes map to banks as follows: user 0x10 and system 0x1F share bank 0, supervisor 0x13 bank 1, abort 0x17 bank 2, undefined 0x1B bank 3, IRQ 0x12 bank 4 and FIQ 0x11 bank 5.
- R3: Registers 13 and 14 and the saved status word each have one copy per bank. A value written in one mode reads back again after leaving that mode and returning to it, and other banks do not see it.
- R4: Registers 8 to 12 have two copies. One is used only in FIQ mode (0x11), the other in all other modes.
- R5: Registers 0 to 7 and register 15 have a single copy that every mode reads and writes.
- R6: An accepted mode request updates `cur_mode` at the next clock edge. From that cycle on, reads return the new mode's copies.
- R7: A request for the mode that is already current changes nothing.
- R8: A request with an illegal code sets `mode_err` high in the following cycle. The mode and all stored values stay unchanged.
- R9: A register write in the same cycle as an accepted mode change lands in the copy that belongs to the old mode.
- R10: `mode_err` is high only in the cycle after an illegal request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register number to write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Register number to read |
| rd_data | output | 32 | Combinational read data for the current mode |
| psr_wr_en | input | 1 | Saved status word write enable |
| psr_wr_data | input | 32 | Saved status word write data |
| psr_rd_data | output | 32 | Saved status word of the current mode |
| mode_req_v | input | 1 | Mode-change request valid |
| mode_req | input | 5 | Requested mode code |
| cur_mode | output | 5 | Current mode code |
| mode_err | output | 1 | Illegal mode code seen in the previous cycle |

## Verification
The bench builds the block with its default parameters: 32-bit data, sixteen registers, six banks, and a fast-interrupt window of five registers starting at register 8. With these values the bench can visit every legal mode and check that user and system share one bank. It also crosses the edges of the fast-interrupt window, where a write to register 9 made in the same cycle as the entry into FIQ mode must land in the ordinary copy. Directed steps cover the values after reset, the bank-private status word, the register that is never banked, and an illegal code followed by a quiet cycle.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  localparam int MODE_W = 5;
  localparam int BANKS  = 6;
  localparam int BANK_W = 3;

  localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

  typedef struct packed {
    logic              ok;
    logic [BANK_W-1:0] bank;
  } bank_sel_t;

  // Maps a mode code to its bank; ok is low for codes outside the legal set.
  function automatic bank_sel_t mode_to_bank(input logic [MODE_W-1:0] m);
    bank_sel_t r;
    r.ok = 1'b1;
    case (m)
      MODE_USR, MODE_SYS: r.bank = 3'd0;
      MODE_SVC:           r.bank = 3'd1;
      MODE_ABT:           r.bank = 3'd2;
      MODE_UND:           r.bank = 3'd3;
      MODE_IRQ:           r.bank = 3'd4;
      MODE_FIQ:           r.bank = 3'd5;
      default: begin
        r.ok   = 1'b0;
        r.bank = 3'd0;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mbr_mode_ctrl.sv
module mbr_mode_ctrl
  import mbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_v,
  input  logic [MODE_W-1:0] req_mode,
  output logic [MODE_W-1:0] cur_mode,
  output logic [BANK_W-1:0] cur_bank,
  output logic              in_fiq,
  output logic              err,
  output logic              sw_evt,
  output logic              bad_evt
);
  logic [MODE_W-1:0] cur_q;
  logic              err_q;
  bank_sel_t         req_sel;
  bank_sel_t         cur_sel;

  always_comb begin
    req_sel = mode_to_bank(req_mode);
    cur_sel = mode_to_bank(cur_q);
    sw_evt  = req_v && req_sel.ok && (req_mode != cur_q);
    bad_evt = req_v && !req_sel.ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= MODE_SVC;
      err_q <= 1'b0;
    end else begin
      err_q <= bad_evt;
      if (sw_evt) cur_q <= req_mode;
    end
  end

  assign cur_mode = cur_q;
  assign cur_bank = cur_sel.bank;
  assign in_fiq   = (cur_q == MODE_FIQ);
  assign err      = err_q;
endmodule

// File: rtl/mbr_bank_store.sv
module mbr_bank_store
  import mbr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank,
  input  logic              we_sp,
  input  logic              we_lr,
  input  logic              we_psr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] psr_wdata,
  output logic [DATA_W-1:0] sp,
  output logic [DATA_W-1:0] lr,
  output logic [DATA_W-1:0] psr
);
  logic [DATA_W-1:0] sp_q  [BANKS];
  logic [DATA_W-1:0] lr_q  [BANKS];
  logic [DATA_W-1:0] psr_q [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank == BANK_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sp_q[b]  <= '0;
        lr_q[b]  <= '0;
        psr_q[b] <= '0;
      end else if (hit) begin
        if (we_sp)  sp_q[b]  <= wdata;
        if (we_lr)  lr_q[b]  <= wdata;
        if (we_psr) psr_q[b] <= psr_wdata;
      end
    end
  end

  assign sp  = sp_q[bank];
  assign lr  = lr_q[bank];
  assign psr = psr_q[bank];
endmodule

// File: rtl/mbr_gpr_store.sv
module mbr_gpr_store #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  parameter int FIQ_LO   = 8,
  parameter int FIQ_N    = 5,
  localparam int AW      = $clog2(NUM_REGS),
  localparam int FW      = $clog2(FIQ_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_fiq,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] main_q [NUM_REGS];
  logic [DATA_W-1:0] fiq_q  [FIQ_N];

  function automatic logic in_window(input logic [AW-1:0] a);
    return (32'(a) >= FIQ_LO) && (32'(a) < FIQ_LO + FIQ_N);
  endfunction

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_main
    localparam bit SHADOWED = (i >= FIQ_LO) && (i < FIQ_LO + FIQ_N);
    logic we;
    assign we = wr_en && (wr_addr == AW'(i)) && !(SHADOWED && in_fiq);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  main_q[i] <= '0;
      else if (we) main_q[i] <= wr_data;
    end
  end

  for (genvar j = 0; j < FIQ_N; j++) begin : g_fiq
    logic we;
    assign we = wr_en && in_fiq && (wr_addr == AW'(FIQ_LO + j));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  fiq_q[j] <= '0;
      else if (we) fiq_q[j] <= wr_data;
    end
  end

  always_comb begin
    if (in_fiq && in_window(rd_addr))
      rd_data = fiq_q[FW'(rd_addr - AW'(FIQ_LO))];
    else
      rd_data = main_q[rd_addr];
  end
endmodule

// File: rtl/mode_bank_regfile.sv
module mode_bank_regfile
  import mbr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  parameter int FIQ_LO   = 8,
  parameter int FIQ_N    = 5,
  parameter int SP_IDX   = 13,
  parameter int LR_IDX   = 14,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              psr_wr_en,
  input  logic [DATA_W-1:0] psr_wr_data,
  output logic [DATA_W-1:0] psr_rd_data,
  input  logic              mode_req_v,
  input  logic [MODE_W-1:0] mode_req,
  output logic [MODE_W-1:0] cur_mode,
  output logic              mode_err
);
  logic [BANK_W-1:0] cur_bank;
  logic              in_fiq;
  logic              sw_evt;
  logic              bad_evt;
  logic              hit_sp, hit_lr;
  logic [DATA_W-1:0] sp_val, lr_val, gpr_val;

  assign hit_sp = wr_en && (wr_addr == AW'(SP_IDX));
  assign hit_lr = wr_en && (wr_addr == AW'(LR_IDX));

  mbr_mode_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_v    (mode_req_v),
    .req_mode (mode_req),
    .cur_mode (cur_mode),
    .cur_bank (cur_bank),
    .in_fiq   (in_fiq),
    .err      (mode_err),
    .sw_evt   (sw_evt),
    .bad_evt  (bad_evt)
  );

  mbr_bank_store #(.DATA_W(DATA_W)) u_banks (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank      (cur_bank),
    .we_sp     (hit_sp),
    .we_lr     (hit_lr),
    .we_psr    (psr_wr_en),
    .wdata     (wr_data),
    .psr_wdata (psr_wr_data),
    .sp        (sp_val),
    .lr        (lr_val),
    .psr       (psr_rd_data)
  );

  mbr_gpr_store #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .FIQ_LO   (FIQ_LO),
    .FIQ_N    (FIQ_N)
  ) u_gpr (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_fiq  (in_fiq),
    .wr_en   (wr_en && !hit_sp && !hit_lr),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (gpr_val)
  );

  always_comb begin
    if (rd_addr == AW'(SP_IDX))      rd_data = sp_val;
    else if (rd_addr == AW'(LR_IDX)) rd_data = lr_val;
    else                             rd_data = gpr_val;
  end
endmodule

// File: rtl/mbr_checker.sv
module mbr_checker
  import mbr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mode_req_v,
  input logic [MODE_W-1:0] mode_req,
  input logic [MODE_W-1:0] cur_mode,
  input logic              mode_err,
  input logic              sw_evt,
  input logic              bad_evt
);
  bank_sel_t cur_sel;
  assign cur_sel = mode_to_bank(cur_mode);

  a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cur_sel.ok);

  a_r6_switch_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    sw_evt |=> cur_mode == $past(mode_req));

  a_r7_same_mode_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req_v && mode_req == cur_mode) |=> ($stable(cur_mode) && !mode_err));

  a_r8_bad_code_flag: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt |=> (mode_err && $stable(cur_mode)));

  a_r10_err_only_after_bad: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_evt |=> !mode_err);
endmodule

bind mode_bank_regfile mbr_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_req_v (mode_req_v),
  .mode_req   (mode_req),
  .cur_mode   (cur_mode),
  .mode_err   (mode_err),
  .sw_evt     (sw_evt),
  .bad_evt    (bad_evt)
);

// File: tb/mode_bank_regfile_tb_top.sv
module mode_bank_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        psr_wr_en = 1'b0;
  logic [31:0] psr_wr_data = '0;
  logic [31:0] psr_rd_data;
  logic        mode_req_v = 1'b0;
  logic [4:0]  mode_req = '0;
  logic [4:0]  cur_mode;
  logic        mode_err;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mode_bank_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .psr_wr_en(psr_wr_en),
    .psr_wr_data(psr_wr_data), .psr_rd_data(psr_rd_data), .mode_req_v(mode_req_v),
    .mode_req(mode_req), .cur_mode(cur_mode), .mode_err(mode_err)
  );

  // {req_v, req_mode, wr_en, wr_addr, wr_data, chk_addr, chk_data, exp_mode}
  localparam int NV = 14;
  localparam logic [83:0] VEC [NV] = '{
    {1'b0, 5'h00, 1'b1, 4'd13, 32'h0000_00A1, 4'd13, 32'h0000_00A1, 5'h13}, // R3 svc sp
    {1'b1, 5'h11, 1'b1, 4'd9,  32'h0000_00B9, 4'd13, 32'h0000_0000, 5'h11}, // R9 R6 R3
    {1'b0, 5'h00, 1'b1, 4'd9,  32'h0000_00F9, 4'd9,  32'h0000_00F9, 5'h11}, // R4 fiq copy
    {1'b1, 5'h10, 1'b0, 4'd0,  32'h0000_0000, 4'd9,  32'h0000_00B9, 5'h10}, // R4 R9 normal copy
    {1'b0, 5'h00, 1'b1, 4'd13, 32'h0000_00C3, 4'd13, 32'h0000_00C3, 5'h10}, // R3 usr sp
    {1'b1, 5'h1F, 1'b0, 4'd0,  32'h0000_0000, 4'd13, 32'h0000_00C3, 5'h1F}, // R2 usr/sys shared
    {1'b1, 5'h13, 1'b0, 4'd0,  32'h0000_0000, 4'd13, 32'h0000_00A1, 5'h13}, // R3 svc sp kept
    {1'b0, 5'h00, 1'b1, 4'd3,  32'h0000_0033, 4'd3,  32'h0000_0033, 5'h13}, // R5 r3
    {1'b1, 5'h12, 1'b0, 4'd0,  32'h0000_0000, 4'd3,  32'h0000_0033, 5'h12}, // R5 shared
    {1'b1, 5'h15, 1'b0, 4'd0,  32'h0000_0000, 4'd3,  32'h0000_0033, 5'h12}, // R8 bad code
    {1'b1, 5'h12, 1'b1, 4'd14, 32'h0000_00E4, 4'd14, 32'h0000_00E4, 5'h12}, // R7 same mode
    {1'b1, 5'h17, 1'b0, 4'd0,  32'h0000_0000, 4'd14, 32'h0000_0000, 5'h17}, // R3 abt lr
    {1'b1, 5'h11, 1'b0, 4'd0,  32'h0000_0000, 4'd9,  32'h0000_00F9, 5'h11}, // R4 fiq again
    {1'b1, 5'h1B, 1'b0, 4'd0,  32'h0000_0000, 4'd9,  32'h0000_00B9, 5'h1B}  // R2 und
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FIX FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic rv, input logic [4:0] rm, input logic we,
                      input logic [3:0] wa, input logic [31:0] wd,
                      input logic pwe, input logic [31:0] pwd);
    mode_req_v = rv; mode_req = rm; wr_en = we; wr_addr = wa; wr_data = wd;
    psr_wr_en = pwe; psr_wr_data = pwd;
    @(negedge clk);
    mode_req_v = 1'b0; wr_en = 1'b0; psr_wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 mode", 32'(cur_mode), 32'h13);
    check("R1 err", 32'(mode_err), 32'h0);
    check("R1 psr", psr_rd_data, 32'h0);
    for (int a = 0; a < 16; a++) begin
      rd_addr = 4'(a); #1;
      check("R1 reg", rd_data, 32'h0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][83], VEC[v][82:78], VEC[v][77], VEC[v][76:73], VEC[v][72:41], 1'b0, '0);
      rd_addr = VEC[v][40:37]; #1;
      check($sformatf("R6 vec%0d mode", v), 32'(cur_mode), 32'(VEC[v][4:0]));
      check($sformatf("R3/R4/R5 vec%0d data", v), rd_data, VEC[v][36:5]);
    end

    // R3 saved status private per bank (now in und)
    step(1'b0, 5'h00, 1'b0, 4'd0, '0, 1'b1, 32'h0000_0077);
    check("R3 psr und", psr_rd_data, 32'h77);
    step(1'b1, 5'h17, 1'b0, 4'd0, '0, 1'b0, '0);
    check("R3 psr abt", psr_rd_data, 32'h0);
    step(1'b1, 5'h1B, 1'b0, 4'd0, '0, 1'b0, '0);
    check("R3 psr und back", psr_rd_data, 32'h77);

    // R5 register 15 never banked
    step(1'b0, 5'h00, 1'b1, 4'd15, 32'h0000_0F15, 1'b0, '0);
    step(1'b1, 5'h11, 1'b0, 4'd0, '0, 1'b0, '0);
    rd_addr = 4'd15; #1;
    check("R5 r15 in fiq", rd_data, 32'hF15);

    // R8 R10 illegal code, then quiet cycle
    step(1'b1, 5'h00, 1'b1, 4'd15, 32'h0, 1'b0, '0);
    check("R8 err set", 32'(mode_err), 32'h1);
    check("R8 mode kept", 32'(cur_mode), 32'h11);
    rd_addr = 4'd9; #1;
    check("R8 fiq r9 kept", rd_data, 32'hF9);
    step(1'b0, 5'h00, 1'b0, 4'd0, '0, 1'b0, '0);
    check("R10 err clear", 32'(mode_err), 32'h0);

    // R7 same mode: no error, no change
    step(1'b1, 5'h11, 1'b0, 4'd0, '0, 1'b0, '0);
    check("R7 err", 32'(mode_err), 32'h0);
    check("R7 mode", 32'(cur_mode), 32'h11);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule